// File: doc/BRIEF.md
# Sticky Interrupt Enable/Status Register Bank

This block collects thirteen single-cycle event pulses from a serial controller's datapath and holds each one in a sticky status bit until the host clears it by writing a one to that bit. A separate mask decides which status bits may raise the single interrupt line. The host never writes the mask directly: one address sets mask bits wherever the written word has ones, and another address clears mask bits wherever the written word has ones. A third address returns the mask for reading only.

The host side is a plain single-cycle port with a write strobe, a read strobe, a byte address and a 32-bit data word. Read data and the interrupt line both come from registers, so each follows its cause by one clock. Status bits capture events whatever the mask holds. A host can therefore poll sources that it keeps masked and later enable them without losing history.

Top module: `irq_status_bank`

## Requirements
- R1: After a synchronous active-high reset the mask is all zeros, every status bit is zero, `irq_out` is 0 and `host_rdata` is 0.
- R2: A one on `evt_pulse[i]` sets status bit i at the next clock edge regardless of the mask, and the bit stays set with no further pulse. Status bit order from bit 0: RX trigger, RX empty, RX full, TX empty, TX full, RX overflow, framing error, parity error, RX timeout, modem-status change, TX trigger, TX nearly full, TX overflow.
- R3: A write to address 0x08 sets each mask bit whose `host_wdata` bit is 1 and leaves mask bits written with 0 unchanged.
- R4: A write to address 0x0C clears each mask bit whose `host_wdata` bit is 1 and leaves mask bits written with 0 unchanged.
- R5: Address 0x10 reads the mask in bits 12:0. Writes to 0x10 leave the mask unchanged.
- R6: A write to address 0x14 clears each status bit whose `host_wdata` bit is 1 and leaves the others alone. Writing 0x1FFF clears all thirteen.
- R7: When an event pulse and a write-one-to-clear of the same status bit fall in one cycle, the bit is set afterwards.
- R8: `irq_out` is registered: in each cycle it equals the OR over all bits of (status AND mask) as they stood in the previous cycle.
- R9: A read strobe returns its data on `host_rdata` in the following cycle. Address 0x14 returns the status and 0x10 returns the mask, in bits 12:0. Every other address, and every cycle without a read strobe, returns zero. Bits 31:13 are always zero.
- R10: Reading the status does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| host_addr | input | 6 | Byte address of the register accessed |
| host_wdata | input | 32 | Host write data |
| evt_pulse | input | 13 | Event pulses from the datapath, one bit per source |
| host_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The event capture and the host's write-one-to-clear can both touch the same status bit in one cycle. The bench provokes this with a directed write to 0x14 that clears two bits while a pulse arrives on one of them. It expects the pulsed bit to remain set and the other bit to be cleared. A pseudo-random stretch then overlaps pulses, mask writes, status clears and reads freely. A behavioural reference model checks the registered read data and the interrupt line against the design on every clock.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  // Host-visible register offsets (byte addresses)
  localparam int unsigned OFS_MASK_SET = 32'h08;
  localparam int unsigned OFS_MASK_CLR = 32'h0C;
  localparam int unsigned OFS_MASK_RD  = 32'h10;
  localparam int unsigned OFS_STATUS   = 32'h14;

  // Source positions within the status and mask vectors
  typedef enum int unsigned {
    SRC_RX_TRIG     = 0,
    SRC_RX_EMPTY    = 1,
    SRC_RX_FULL     = 2,
    SRC_TX_EMPTY    = 3,
    SRC_TX_FULL     = 4,
    SRC_RX_OVERRUN  = 5,
    SRC_FRAME_ERR   = 6,
    SRC_PARITY_ERR  = 7,
    SRC_RX_TIMEOUT  = 8,
    SRC_MODEM_DELTA = 9,
    SRC_TX_TRIG     = 10,
    SRC_TX_NEARFULL = 11,
    SRC_TX_OVERRUN  = 12
  } irq_src_e;

  localparam int unsigned NUM_IRQ_SRC = 13;

endpackage

// File: rtl/irq_host_decode.sv
module irq_host_decode
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 13
) (
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic [NUM_SRC-1:0] status_q,
  output logic [NUM_SRC-1:0] mask_set,
  output logic [NUM_SRC-1:0] mask_clr,
  output logic [NUM_SRC-1:0] status_ack,
  output logic [DATA_W-1:0]  rdata_d
);

  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_MASK_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_MASK_CLR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK_RD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);

  logic [NUM_SRC-1:0] wbits;
  logic               unused_wdata_hi;

  assign wbits           = host_wdata[NUM_SRC-1:0];
  assign unused_wdata_hi = ^host_wdata[DATA_W-1:NUM_SRC];

  always_comb begin
    mask_set   = '0;
    mask_clr   = '0;
    status_ack = '0;
    if (host_wr) begin
      unique case (host_addr)
        A_SET:   mask_set   = wbits;
        A_CLR:   mask_clr   = wbits;
        A_STAT:  status_ack = wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_d = '0;
    if (host_rd) begin
      unique case (host_addr)
        A_MASK:  rdata_d = DATA_W'(mask_q);
        A_STAT:  rdata_d = DATA_W'(status_q);
        default: rdata_d = '0;
      endcase
    end
  end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_SRC = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] mask_set,
  input  logic [NUM_SRC-1:0] mask_clr,
  output logic [NUM_SRC-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= (mask_q | mask_set) & ~mask_clr;
  end

  // R1
  mask_reset_chk: assert property (@(posedge clk) rst |=> (mask_q == '0));
  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_set != '0) |=> ((mask_q & $past(mask_set)) == $past(mask_set)));
  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_clr != '0) |=> ((mask_q & $past(mask_clr)) == '0));
  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_set == '0 && mask_clr == '0) |=> $stable(mask_q));

endmodule

// File: rtl/irq_sticky_status.sv
module irq_sticky_status #(
  parameter int NUM_SRC = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic [NUM_SRC-1:0] status_ack,
  output logic [NUM_SRC-1:0] status_q
);

  // Event capture takes priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~status_ack) | evt_pulse;
  end

  // R1
  status_reset_chk: assert property (@(posedge clk) rst |=> (status_q == '0));
  // R2, R7
  evt_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_pulse != '0) |=> ((status_q & $past(evt_pulse)) == $past(evt_pulse)));
  // R2, R10
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status_ack == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (status_ack != '0) |=> ((status_q & $past(status_ack & ~evt_pulse)) == '0));

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = NUM_IRQ_SRC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic [NUM_SRC-1:0] evt_pulse,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               irq_out
);

  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_set;
  logic [NUM_SRC-1:0] mask_clr;
  logic [NUM_SRC-1:0] status_ack;
  logic [DATA_W-1:0]  rdata_d;

  irq_host_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_SRC(NUM_SRC)
  ) u_decode (
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .mask_q    (mask_q),
    .status_q  (status_q),
    .mask_set  (mask_set),
    .mask_clr  (mask_clr),
    .status_ack(status_ack),
    .rdata_d   (rdata_d)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .mask_set(mask_set),
    .mask_clr(mask_clr),
    .mask_q  (mask_q)
  );

  irq_sticky_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk       (clk),
    .rst       (rst),
    .evt_pulse (evt_pulse),
    .status_ack(status_ack),
    .status_q  (status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      irq_out    <= 1'b0;
    end else begin
      host_rdata <= rdata_d;
      irq_out    <= |(status_q & mask_q);
    end
  end

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == $past(|(status_q & mask_q))));
  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> (host_rdata == '0));
  // R9
  rdata_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    host_rdata[DATA_W-1:NUM_SRC] == '0);
  // R1
  out_reset_chk: assert property (@(posedge clk)
    rst |=> (!irq_out && host_rdata == '0));

endmodule

// File: tb/test_irq_status_bank.sv
`timescale 1ns/1ps
module test_irq_status_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [12:0] evt_pulse = '0;
  logic [31:0] host_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_status_bank i_irq_status_bank (
    .clk       (clk),
    .rst       (rst),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .evt_pulse (evt_pulse),
    .host_rdata(host_rdata),
    .irq_out   (irq_out)
  );

  // Behavioural reference model
  logic [12:0] m_status, m_mask;
  logic [31:0] m_rdata;
  logic        m_irq;

  always @(posedge clk) begin
    logic [12:0] st, mk;
    st = m_status;
    mk = m_mask;
    if (rst) begin
      m_status <= '0; m_mask <= '0; m_rdata <= '0; m_irq <= 1'b0;
    end else begin
      m_irq   <= ((st & mk) != 0);
      m_rdata <= !host_rd ? 32'd0 :
                 (host_addr == 6'h10) ? {19'd0, mk} :
                 (host_addr == 6'h14) ? {19'd0, st} : 32'd0;
      if (host_wr && host_addr == 6'h08) mk = mk | host_wdata[12:0];
      if (host_wr && host_addr == 6'h0C) mk = mk & ~host_wdata[12:0];
      if (host_wr && host_addr == 6'h14) st = st & ~host_wdata[12:0];
      st = st | evt_pulse;
      m_status <= st;
      m_mask   <= mk;
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      checks++;
      if (irq_out !== m_irq) begin
        errors++;
        $display("FAIL R8 cycle %0d irq_out act=%b exp=%b", cycles, irq_out, m_irq);
      end
      checks++;
      if (host_rdata !== m_rdata) begin
        errors++;
        $display("FAIL R9 cycle %0d host_rdata act=%h exp=%h", cycles, host_rdata, m_rdata);
      end
    end
  end

  // Watchdog
  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Tasks are entered at a falling edge and return at a falling edge
  task automatic wr_reg(logic [5:0] a, logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = '0;
  endtask

  task automatic rd_reg(logic [5:0] a, output logic [31:0] d);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    d = host_rdata;
    host_rd = 1'b0;
  endtask

  task automatic pulse(logic [12:0] v);
    evt_pulse = v;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 irq_out after reset", {31'd0, irq_out}, 32'd0);
    check("R1 host_rdata after reset", host_rdata, 32'd0);
    rd_reg(6'h10, d); check("R1 mask after reset", d, 32'd0);
    rd_reg(6'h14, d); check("R1 status after reset", d, 32'd0);

    // R2: TX empty (bit 3) latches while masked, stays set
    pulse(13'h0008);
    repeat (5) @(negedge clk);
    rd_reg(6'h14, d); check("R2 sticky TX empty bit 3", d, 32'h8);
    check("R8 masked source gives no irq", {31'd0, irq_out}, 32'd0);
    // R10: a second read sees the same value
    rd_reg(6'h14, d); check("R10 status unchanged by read", d, 32'h8);

    // R3: set mask bits
    wr_reg(6'h08, 32'h0000_0008);
    @(negedge clk);
    check("R8 irq after enabling TX empty", {31'd0, irq_out}, 32'd1);
    wr_reg(6'h08, 32'hFFFF_1000);
    rd_reg(6'h10, d); check("R3 enable leaves zero bits unchanged", d, 32'h1008);

    // R5: writes to the mask address are ignored
    wr_reg(6'h10, 32'h0000_1FFF);
    rd_reg(6'h10, d); check("R5 write to mask address ignored", d, 32'h1008);

    // R4: clear mask bits
    wr_reg(6'h0C, 32'h0000_0008);
    rd_reg(6'h10, d); check("R4 disable clears only bit 3", d, 32'h1000);
    check("R8 irq drops after disable", {31'd0, irq_out}, 32'd0);

    // R6: write-one-to-clear
    pulse(13'h1FFF);
    rd_reg(6'h14, d); check("R2 all sources latched", d, 32'h1FFF);
    wr_reg(6'h14, 32'h0000_0001);
    rd_reg(6'h14, d); check("R6 clear bit 0 only", d, 32'h1FFE);
    wr_reg(6'h14, 32'h0000_1FFF);
    rd_reg(6'h14, d); check("R6 all-sources clear", d, 32'h0);

    // R7: event and clear of bit 5 in one cycle, bit 0 also cleared
    pulse(13'h0001);
    evt_pulse = 13'h0020;
    wr_reg(6'h14, 32'h0000_0021);
    evt_pulse = '0;
    rd_reg(6'h14, d); check("R7 event wins over same-cycle clear", d, 32'h20);

    // R9: non-readable addresses return zero
    rd_reg(6'h08, d); check("R9 enable address reads zero", d, 32'h0);
    rd_reg(6'h0C, d); check("R9 disable address reads zero", d, 32'h0);
    rd_reg(6'h00, d); check("R9 unmapped address reads zero", d, 32'h0);

    // Pseudo-random overlap of all functions, judged by the model
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      evt_pulse  = (lfsr[3:0] == 4'h0) ? lfsr[28:16] : 13'h0;
      host_wr    = lfsr[5] & lfsr[6];
      host_rd    = lfsr[7];
      case (lfsr[9:8])
        2'd0: host_addr = 6'h08;
        2'd1: host_addr = 6'h0C;
        2'd2: host_addr = 6'h10;
        default: host_addr = 6'h14;
      endcase
      host_wdata = {lfsr[15:10], lfsr[31:6]};
      @(negedge clk);
    end
    evt_pulse = '0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
    @(negedge clk);

    // R1: reset mid-run clears everything
    pulse(13'h1FFF);
    wr_reg(6'h08, 32'h1FFF);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_reg(6'h14, d); check("R1 status cleared by reset", d, 32'h0);
    rd_reg(6'h10, d); check("R1 mask cleared by reset", d, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule